// File: doc/BRIEF.md
# Host Bridge Control Register File

This block is the software-visible control bank of a host bridge. It keeps a set of 32-bit words on a simple word-addressed bus: bridge configuration words, an interrupt enable mask, an interrupt status word and four mailbox words. Most words store whatever is written and return it on a read. A few words have write side effects.

The interrupt enable mask cannot be written directly. It changes only through a set word and a clear word. Writing the set word ORs the written value into the mask. Writing the clear word removes every mask bit that is 1 in the written value.

The general configuration word has a CPU self-reset bit. When a write moves that bit from 0 to 1, the block emits a single-cycle system reset request. The general configuration word and the enable mask are also driven out as ports, so that neighbouring logic can use them. Fixed power-on values are loaded by the synchronous reset.

Top module: `hbr_regfile`

## Requirements
- R1: After reset the words hold these values; every other word reads 0, the enable mask is 0 and no reset request is active.

  | Byte offset | Reset value |
  |---|---|
  | 0x00 | 0x00000C40 |
  | 0x04 | 0x00001384 (bits 2, 7, 8, 9 and 12 set) |
  | 0x08 | 0x2BFF8010 |
  | 0x0C | 0x255E0091 |
  | 0x10 | 0x00006140 |
  | 0x1C | 0x000001FF |
  | 0x20 | 0x000001FF |
  | 0x68 | 0x00000008 |
  | 0x6C | 0x10000000 |

- R2: Plain words store the full 32-bit write data. Plain words are every decoded offset other than 0x38 and 0x3C, and they include the mailboxes at 0x40, 0x44, 0x48 and 0x4C. A combinational read returns the stored word in the cycle after the write edge.
- R3: A write to offset 0x30 stores the value in word 0x30 and ORs it into the enable mask, which is read at 0x38. The new mask is visible in the cycle after the write edge.
- R4: A write to offset 0x34 stores the value in word 0x34 and clears each enable mask bit that is 1 in the value.
- R5: Writes to offset 0x38 (enable mask) and offset 0x3C (status, which reads 0) change nothing.
- R6: Offsets 0x70 to 0x7C are undecoded. Reads of them return 0, and writes to them change no word.
- R7: A write to offset 0x04 that finds bit 2 at 0 and writes bit 2 as 1 raises `sys_reset_req` for exactly the one cycle after the write edge.
- R8: A write to offset 0x04 raises no request when bit 2 was already 1, or when bit 2 is written as 0.
- R9: `gen_cfg` always equals word 0x04, and `int_enable` always equals the mask read at 0x38.
- R10: Address bits [1:0] are ignored. Only bits [6:2] select the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 7 | Byte address; bits [6:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| gen_cfg | output | 32 | Current general configuration word |
| int_enable | output | 32 | Current interrupt enable mask |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
Every write takes effect at the clock edge where `bus_wr` is high, so both the stored words and the reset request change in the cycle that follows that edge. Reads need no cycles, because `bus_rdata` is combinational. The bench drives each input at a falling edge and samples one falling edge after a write, or shortly after setting the address for a read. It therefore sees a request pulse, and a mask updated by the set or clear words, in their due cycle. It then checks at the next falling edge that the pulse has dropped again.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

    localparam int unsigned HBR_DATA_W    = 32;
    localparam int unsigned HBR_ADDR_W    = 7;
    localparam int unsigned HBR_NUM_WORDS = 28;

    // word indices (byte offset / 4) whose behaviour is special
    localparam int unsigned IDX_PONCFG = 0;
    localparam int unsigned IDX_GENCFG = 1;
    localparam int unsigned IDX_IODEV  = 2;
    localparam int unsigned IDX_SDRAM  = 3;
    localparam int unsigned IDX_PCIMAP = 4;
    localparam int unsigned IDX_GPDATA = 7;
    localparam int unsigned IDX_GPIE   = 8;
    localparam int unsigned IDX_ENSET  = 12;
    localparam int unsigned IDX_ENCLR  = 13;
    localparam int unsigned IDX_ENABLE = 14;
    localparam int unsigned IDX_STATUS = 15;
    localparam int unsigned IDX_DQ     = 26;
    localparam int unsigned IDX_MSIZE  = 27;

    // general configuration field positions
    localparam int unsigned GC_DEBUG    = 0;
    localparam int unsigned GC_SNOOP    = 1;
    localparam int unsigned GC_SELFRST  = 2;
    localparam int unsigned GC_SWAP     = 6;
    localparam int unsigned GC_UNCACHED = 7;
    localparam int unsigned GC_PREFETCH = 8;
    localparam int unsigned GC_WBEHIND  = 9;
    localparam int unsigned GC_PCIQ     = 12;

    typedef struct packed {
        logic set_en;
        logic clr_en;
        logic gen_wr;
    } hbr_side_t;

    function automatic logic [31:0] gen_cfg_reset();
        logic [31:0] v;
        v = '0;
        v[GC_SELFRST]  = 1'b1;
        v[GC_UNCACHED] = 1'b1;
        v[GC_PREFETCH] = 1'b1;
        v[GC_WBEHIND]  = 1'b1;
        v[GC_PCIQ]     = 1'b1;
        return v;
    endfunction

    function automatic logic [31:0] word_reset_value(int unsigned idx);
        case (idx)
            IDX_PONCFG: return 32'h0000_0C40;
            IDX_GENCFG: return gen_cfg_reset();
            IDX_IODEV:  return 32'h2BFF_8010;
            IDX_SDRAM:  return 32'h255E_0091;
            IDX_PCIMAP: return 32'h0000_6140;
            IDX_GPDATA: return 32'h0000_01FF;
            IDX_GPIE:   return 32'h0000_01FF;
            IDX_DQ:     return 32'h0000_0008;
            IDX_MSIZE:  return 32'h1000_0000;
            default:    return 32'h0000_0000;
        endcase
    endfunction

    function automatic logic word_writable(int unsigned idx);
        return (idx != IDX_ENABLE) && (idx != IDX_STATUS);
    endfunction

endpackage

// File: rtl/hbr_decode.sv
module hbr_decode
    import hbr_pkg::*;
#(
    parameter int unsigned ADDR_W    = HBR_ADDR_W,
    parameter int unsigned NUM_WORDS = HBR_NUM_WORDS,
    localparam int unsigned IDX_W    = ADDR_W - 2
) (
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    output logic [NUM_WORDS-1:0] word_we,
    output hbr_side_t            side,
    output logic [IDX_W-1:0]     rd_idx,
    output logic                 rd_hit
);

    logic [IDX_W-1:0] idx;

    always_comb begin
        idx    = bus_addr[ADDR_W-1:2];
        rd_idx = idx;
        rd_hit = (int'(idx) < NUM_WORDS);
        for (int i = 0; i < NUM_WORDS; i++) begin
            word_we[i] = bus_wr && (idx == IDX_W'(i)) && word_writable(i);
        end
        side.set_en = bus_wr && (idx == IDX_W'(IDX_ENSET));
        side.clr_en = bus_wr && (idx == IDX_W'(IDX_ENCLR));
        side.gen_wr = bus_wr && (idx == IDX_W'(IDX_GENCFG));
    end

endmodule

// File: rtl/hbr_word_reg.sv
module hbr_word_reg #(
    parameter int unsigned         DATA_W    = 32,
    parameter logic [DATA_W-1:0]   RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RESET_VAL;
        end else if (we) begin
            q <= wdata;
        end
    end

endmodule

// File: rtl/hbr_enable_unit.sv
module hbr_enable_unit #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] en_q
);

    logic [DATA_W-1:0] en_next;

    always_comb begin
        en_next = en_q;
        if (set_en) en_next = en_next | wdata;
        if (clr_en) en_next = en_next & ~wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= en_next;
    end

endmodule

// File: rtl/hbr_selfreset.sv
module hbr_selfreset #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned BIT    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gen_wr,
    input  logic [DATA_W-1:0] cur_word,
    input  logic [DATA_W-1:0] wdata,
    output logic              req
);

    always_ff @(posedge clk) begin
        if (rst) req <= 1'b0;
        else     req <= gen_wr && !cur_word[BIT] && wdata[BIT];
    end

endmodule

// File: rtl/hbr_regfile.sv
module hbr_regfile
    import hbr_pkg::*;
#(
    parameter int unsigned DATA_W    = HBR_DATA_W,
    parameter int unsigned ADDR_W    = HBR_ADDR_W,
    parameter int unsigned NUM_WORDS = HBR_NUM_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] gen_cfg,
    output logic [DATA_W-1:0] int_enable,
    output logic              sys_reset_req
);

    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [NUM_WORDS-1:0] word_we;
    hbr_side_t            side;
    logic [IDX_W-1:0]     rd_idx;
    logic                 rd_hit;
    logic [DATA_W-1:0]    word_q [NUM_WORDS];
    logic [DATA_W-1:0]    en_q;

    hbr_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) dec_i (
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .word_we (word_we),
        .side    (side),
        .rd_idx  (rd_idx),
        .rd_hit  (rd_hit)
    );

    hbr_enable_unit #(.DATA_W(DATA_W)) en_i (
        .clk   (clk),
        .rst   (rst),
        .set_en(side.set_en),
        .clr_en(side.clr_en),
        .wdata (bus_wdata),
        .en_q  (en_q)
    );

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        if (i == IDX_ENABLE) begin : g_en
            assign word_q[i] = en_q;
        end else if (i == IDX_STATUS) begin : g_st
            assign word_q[i] = '0;
        end else begin : g_reg
            hbr_word_reg #(
                .DATA_W   (DATA_W),
                .RESET_VAL(DATA_W'(word_reset_value(i)))
            ) reg_i (
                .clk  (clk),
                .rst  (rst),
                .we   (word_we[i]),
                .wdata(bus_wdata),
                .q    (word_q[i])
            );
        end
    end

    hbr_selfreset #(.DATA_W(DATA_W), .BIT(GC_SELFRST)) sr_i (
        .clk     (clk),
        .rst     (rst),
        .gen_wr  (side.gen_wr),
        .cur_word(word_q[IDX_GENCFG]),
        .wdata   (bus_wdata),
        .req     (sys_reset_req)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_hit) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                if (rd_idx == IDX_W'(i)) bus_rdata = word_q[i];
            end
        end
    end

    assign gen_cfg    = word_q[IDX_GENCFG];
    assign int_enable = en_q;

endmodule

// File: rtl/hbr_regfile_chk.sv
module hbr_regfile_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] gen_cfg,
    input logic [DATA_W-1:0] int_enable,
    input logic              sys_reset_req
);

    localparam int unsigned IDX_W = ADDR_W - 2;

    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    logic [IDX_W-1:0] idx;
    assign idx = bus_addr[ADDR_W-1:2];

    assert_set_or_R3: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(bus_wr && idx == IDX_W'(12)) |-> int_enable == ($past(int_enable) | $past(bus_wdata)));

    assert_clear_and_R4: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(bus_wr && idx == IDX_W'(13)) |-> int_enable == ($past(int_enable) & ~$past(bus_wdata)));

    assert_enable_hold_R5: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(!(bus_wr && (idx == IDX_W'(12) || idx == IDX_W'(13)))) |-> $stable(int_enable));

    assert_undecoded_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (int'(idx) >= 28) |-> bus_rdata == '0);

    assert_req_cause_R7: assert property (@(posedge clk) disable iff (rst || !armed)
        sys_reset_req |-> $past(bus_wr && idx == IDX_W'(1) && bus_wdata[2] && !gen_cfg[2]));

    assert_req_single_R7: assert property (@(posedge clk) disable iff (rst)
        sys_reset_req |=> !sys_reset_req);

    assert_gen_write_R9: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(bus_wr && idx == IDX_W'(1)) |-> gen_cfg == $past(bus_wdata));

endmodule

bind hbr_regfile hbr_regfile_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .gen_cfg      (gen_cfg),
    .int_enable   (int_enable),
    .sys_reset_req(sys_reset_req)
);

// File: tb/hbr_regfile_tb_top.sv
`timescale 1ns/1ps
module hbr_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] gen_cfg;
    logic [31:0] int_enable;
    logic        sys_reset_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hbr_regfile dut_i (
        .clk          (clk),
        .rst          (rst),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .gen_cfg      (gen_cfg),
        .int_enable   (int_enable),
        .sys_reset_req(sys_reset_req)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // write strobe across one rising edge; returns at the following falling edge
    task automatic wr(logic [6:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(string req, logic [6:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic t_reset();
        rd_check("R1", 7'h00, 32'h0000_0C40);
        rd_check("R1", 7'h04, 32'h0000_1384);
        rd_check("R1", 7'h08, 32'h2BFF_8010);
        rd_check("R1", 7'h0C, 32'h255E_0091);
        rd_check("R1", 7'h10, 32'h0000_6140);
        rd_check("R1", 7'h1C, 32'h0000_01FF);
        rd_check("R1", 7'h20, 32'h0000_01FF);
        rd_check("R1", 7'h68, 32'h0000_0008);
        rd_check("R1", 7'h6C, 32'h1000_0000);
        rd_check("R1", 7'h40, 32'h0);
        rd_check("R1", 7'h38, 32'h0);
        check("R1", {31'b0, sys_reset_req}, 32'h0);
        check("R9", gen_cfg, 32'h0000_1384);
        check("R9", int_enable, 32'h0);
    endtask

    task automatic t_plain();
        for (int i = 0; i < 4; i++) wr(7'(8'h40 + 4*i), 32'hA5A5_0000 + i);
        for (int i = 0; i < 4; i++) rd_check("R2", 7'(8'h40 + 4*i), 32'hA5A5_0000 + i);
        wr(7'h68, 32'h1234_5678);
        rd_check("R2", 7'h68, 32'h1234_5678);
        wr(7'h18, 32'hFFFF_FFFF);
        rd_check("R2", 7'h18, 32'hFFFF_FFFF);
    endtask

    task automatic t_set();
        wr(7'h30, 32'h0000_00F0);
        check("R3", int_enable, 32'h0000_00F0);
        rd_check("R3", 7'h38, 32'h0000_00F0);
        rd_check("R3", 7'h30, 32'h0000_00F0);
        wr(7'h30, 32'h0000_0F00);
        check("R3", int_enable, 32'h0000_0FF0);
    endtask

    task automatic t_clear();
        wr(7'h34, 32'h0000_0030);
        check("R4", int_enable, 32'h0000_0FC0);
        rd_check("R4", 7'h34, 32'h0000_0030);
        rd_check("R9", 7'h38, int_enable);
    endtask

    task automatic t_readonly();
        wr(7'h38, 32'hFFFF_FFFF);
        check("R5", int_enable, 32'h0000_0FC0);
        wr(7'h3C, 32'hDEAD_BEEF);
        rd_check("R5", 7'h3C, 32'h0);
    endtask

    task automatic t_undecoded();
        wr(7'h70, 32'hCAFE_F00D);
        rd_check("R6", 7'h70, 32'h0);
        rd_check("R6", 7'h7C, 32'h0);
        rd_check("R6", 7'h40, 32'hA5A5_0000);
        rd_check("R6", 7'h00, 32'h0000_0C40);
    endtask

    task automatic t_selfreset();
        wr(7'h04, 32'h0000_1384);
        check("R8", {31'b0, sys_reset_req}, 32'h0);
        wr(7'h04, 32'h0000_1380);
        check("R8", {31'b0, sys_reset_req}, 32'h0);
        check("R9", gen_cfg, 32'h0000_1380);
        wr(7'h04, 32'h0000_0004);
        check("R7", {31'b0, sys_reset_req}, 32'h1);
        check("R9", gen_cfg, 32'h0000_0004);
        @(negedge clk);
        check("R7", {31'b0, sys_reset_req}, 32'h0);
        wr(7'h04, 32'h0000_0004);
        check("R8", {31'b0, sys_reset_req}, 32'h0);
    endtask

    task automatic t_lowbits();
        wr(7'h47, 32'h0BAD_CAFE);
        rd_check("R10", 7'h44, 32'h0BAD_CAFE);
        rd_check("R10", 7'h45, 32'h0BAD_CAFE);
        rd_check("R10", 7'h40, 32'hA5A5_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_plain();
        t_set();
        t_clear();
        t_readonly();
        t_undecoded();
        t_selfreset();
        t_lowbits();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule